// File: doc/BRIEF.md
# Recursive Adder-Based Squarer

This block returns the exact square of an unsigned N-bit operand as a 2N-bit result. It does not use a general multiplier. The operand is split into its most significant bit and the (N-1)-bit remainder below it. The remainder is squared by a narrower unit of the same construction. That unit recurses in turn, down to a one-bit squarer that passes its input straight through.

When the split-off bit is set, a correction term is added to the narrower square. The term is the remainder plus 2^(N-2), formed in an N-bit adder and then shifted left by N bits. A 2N-bit ripple-carry adder produces the final sum, and the result is captured in an output register. An optional pipeline register sits between the narrower-square stage and the final summation.

The operand is presented with a valid strobe. The strobe travels with the data, so a valid output marks each result.

Top module: `sqr_top`

## Requirements
- R1: For every operand value, the result presented with `res_valid` equals the operand multiplied by itself, exactly.
- R2: When operand bit N-1 is 0, the result equals the square of the lower N-1 bits, zero-extended to 2N bits.
- R3: Result bit 0 always equals operand bit 0.
- R4: Result bit 1 is always 0.
- R5: With `MID_STAGE`=1 (default), a result and its `res_valid` appear on the second rising edge after the edge that samples `op_valid`; with `MID_STAGE`=0 they appear on the first.
- R6: A synchronous reset (`rst` high at a rising edge) clears `res_sq` to 0 and `res_valid` to 0, and discards any operand still in flight.
- R7: In a cycle with no valid operand at the matching input slot, `res_valid` is 0 and `res_sq` holds the last result.
- R8: Operands presented on consecutive cycles each produce their own result, one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand strobe |
| op_in | input | N | Unsigned operand |
| res_valid | output | 1 | Marks a new result |
| res_sq | output | 2N | Registered square of the operand |

## Verification
All 2^N operands are applied back to back. This covers both halves of the split: operands whose top bit is clear exercise only the narrower squarer, and operands whose top bit is set also need the correction addition. The sweep also shows whether results stay in order at full throughput. A second sweep leaves an idle cycle between operands. It separates correct valid tracking and result holding from a design that merely streams. A reset issued while an operand is in flight shows whether the pipeline contents are truly discarded rather than only masked at the output.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
    function automatic int unsigned prod_width(input int unsigned w);
        return 2 * w;
    endfunction
endpackage

// File: rtl/sqr_rca.sv
module sqr_rca #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    // carries into each bit; the carry out of the top bit is not needed
    logic [W-1:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i] = a[i] ^ b[i] ^ c[i];
        if (i < W - 1) begin : g_carry
            assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/sqr_unit.sv
module sqr_unit #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0]   a,
    output logic [2*W-1:0] p
);
    if (W == 1) begin : g_leaf
        assign p = {1'b0, a};
    end else begin : g_split
        localparam int unsigned LW = W - 1;
        localparam int unsigned PW = 2 * W;
        localparam int unsigned SW = 2 * LW;

        logic [LW-1:0] lo;
        logic [SW-1:0] lo_sq;
        logic [W-1:0]  corr;
        logic [PW-1:0] base;
        logic [PW-1:0] term;

        assign lo = a[LW-1:0];

        sqr_unit #(.W(LW)) u_sub (
            .a (lo),
            .p (lo_sq)
        );

        sqr_rca #(.W(W)) u_corr (
            .a ({1'b0, lo}),
            .b (W'(1) << (W - 2)),
            .s (corr)
        );

        assign base = {2'b00, lo_sq};
        assign term = a[W-1] ? {corr, W'(0)} : '0;

        sqr_rca #(.W(PW)) u_sum (
            .a (base),
            .b (term),
            .s (p)
        );

        always_comb begin
            // R3
            lsb_chk: assert (p[0] == a[0]);
            // R4
            bit1_chk: assert (p[1] == 1'b0);
            // R2
            narrow_chk: assert (a[W-1] || p == base);
        end
    end
endmodule

// File: rtl/sqr_top.sv
module sqr_top #(
    parameter int unsigned N         = 4,
    parameter bit          MID_STAGE = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_valid,
    input  logic [N-1:0]                op_in,
    output logic                        res_valid,
    output logic [sqr_pkg::prod_width(N)-1:0] res_sq
);
    localparam int unsigned LW = N - 1;
    localparam int unsigned PW = sqr_pkg::prod_width(N);
    localparam int unsigned SW = 2 * LW;

    typedef struct packed {
        logic          vld;
        logic          top;
        logic [LW-1:0] lo;
        logic [SW-1:0] lo_sq;
    } mid_t;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] sq;
    } out_t;

    mid_t mid_d, mid_q;
    out_t out_d, out_q;

    logic [SW-1:0] lo_sq_w;
    logic [N-1:0]  corr;
    logic [PW-1:0] base;
    logic [PW-1:0] term;
    logic [PW-1:0] total;

    // stage A: narrower square of the lower segment
    sqr_unit #(.W(LW)) u_lo (
        .a (op_in[LW-1:0]),
        .p (lo_sq_w)
    );

    always_comb begin
        mid_d.vld   = op_valid;
        mid_d.top   = op_in[N-1];
        mid_d.lo    = op_in[LW-1:0];
        mid_d.lo_sq = lo_sq_w;
    end

    if (MID_STAGE) begin : g_mid_reg
        always_ff @(posedge clk) begin
            if (rst) mid_q <= '0;
            else     mid_q <= mid_d;
        end
    end else begin : g_mid_pass
        always_comb mid_q = mid_d;
    end

    // stage B: correction term and final summation
    sqr_rca #(.W(N)) u_corr (
        .a ({1'b0, mid_q.lo}),
        .b (N'(1) << (N - 2)),
        .s (corr)
    );

    assign base = {2'b00, mid_q.lo_sq};
    assign term = mid_q.top ? {corr, N'(0)} : '0;

    sqr_rca #(.W(PW)) u_sum (
        .a (base),
        .b (term),
        .s (total)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = mid_q.vld;
        if (mid_q.vld) out_d.sq = total;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign res_valid = out_q.vld;
    assign res_sq    = out_q.sq;

    // R4
    res_bit1_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_sq[1] == 1'b0);

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && res_sq == '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid && !$past(rst) |-> $stable(res_sq));

    if (MID_STAGE) begin : g_lat2
        // R5
        lat_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> $past(op_valid, 2));
        // R3
        lsb_out_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> res_sq[0] == $past(op_in[0], 2));
    end else begin : g_lat1
        // R5
        lat_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> $past(op_valid));
        // R3
        lsb_out_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> res_sq[0] == $past(op_in[0]));
    end
endmodule

// File: tb/sqr_top_tb.sv
module sqr_top_tb;
    localparam int unsigned N      = 4;
    localparam int unsigned PW     = 2 * N;
    localparam int unsigned LAT    = 2;
    localparam time         PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [N-1:0]  op_in = '0;
    logic          res_valid;
    logic [PW-1:0] res_sq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit hv [0:1023];
    int hop [0:1023];
    logic [PW-1:0] last_exp = '0;

    sqr_top #(.N(N), .MID_STAGE(1'b1)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_in     (op_in),
        .res_valid (res_valid),
        .res_sq    (res_sq)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // check the result of the slot LAT cycles back, then drive a new slot
    task automatic step(input bit v, input int op);
        @(negedge clk);
        if (cyc >= int'(LAT)) begin
            int k = cyc - int'(LAT);
            if (hv[k]) begin
                logic [PW-1:0] e = PW'(hop[k] * hop[k]);
                last_exp = e;
                chk(res_valid == 1'b1, "R5/R8 valid", int'(res_valid), 1);
                chk(res_sq == e, "R1 square", int'(res_sq), int'(e));
                chk(res_sq[0] == 1'(hop[k]), "R3 lsb", int'(res_sq[0]), hop[k] & 1);
                chk(res_sq[1] == 1'b0, "R4 bit1", int'(res_sq[1]), 0);
                if (hop[k] < (1 << (N-1)))
                    chk(res_sq == PW'((hop[k] % (1 << (N-1))) ** 2), "R2 narrow",
                        int'(res_sq), (hop[k] % (1 << (N-1))) ** 2);
            end else begin
                chk(res_valid == 1'b0, "R7 idle valid", int'(res_valid), 0);
                chk(res_sq == last_exp, "R7 hold", int'(res_sq), int'(last_exp));
            end
        end
        op_valid = v;
        op_in    = N'(op);
        hv[cyc]  = v;
        hop[cyc] = op;
        cyc++;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin hv[i] = 1'b0; hop[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6: reset state
        chk(res_valid == 1'b0, "R6 reset valid", int'(res_valid), 0);
        chk(res_sq == '0, "R6 reset result", int'(res_sq), 0);

        // R1 R2 R8: back-to-back exhaustive sweep
        for (int v = 0; v < (1 << N); v++) step(1'b1, v);
        // R7: gapped sweep, descending
        for (int v = (1 << N) - 1; v >= 0; v--) begin
            step(1'b1, v);
            step(1'b0, 0);
        end
        for (int i = 0; i < int'(LAT) + 1; i++) step(1'b0, 0);

        // R6: reset with an operand in flight
        step(1'b1, 13);
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(res_valid == 1'b0, "R6 midflight valid", int'(res_valid), 0);
        chk(res_sq == '0, "R6 midflight result", int'(res_sq), 0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R6 flushed stage", int'(res_valid), 0);
        chk(res_sq == '0, "R6 flushed result", int'(res_sq), 0);

        // R5: single operand latency after reset
        @(negedge clk);
        op_valid = 1'b1; op_in = N'(11);
        @(negedge clk);
        op_valid = 1'b0;
        chk(res_valid == 1'b0, "R5 not early", int'(res_valid), 0);
        @(negedge clk);
        chk(res_valid == 1'b1, "R5 on time", int'(res_valid), 1);
        chk(res_sq == PW'(121), "R1 square 11", int'(res_sq), 121);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule